// File: doc/BRIEF.md
# Floating-point control and context-status tracker

This block keeps the architectural control and status state of a single-precision floating-point unit. It stores a 3-bit rounding-mode field and five sticky exception flags, and presents them together as one 32-bit control word. It also stores a 2-bit context-status value that tells privileged software whether the floating-point register file must be saved on a context switch.

Software reaches the state through one combinational read / registered write port with four views: the whole control word, the rounding mode alone, the flags alone, and the context status. Every cycle the execution pipeline may OR newly raised exception bits into the flags, and it raises a strobe whenever it writes a floating-point register. A parameter selects whether that strobe drives the context status to Dirty (value 3) or is ignored. A second parameter, a 4-bit mask, lists which context-status values software may write. Values outside the mask are dropped. The mask must contain 0 and 3, and a misconfigured mask is reported when the design is built.

Top module: `fpctl_tracker`

## Requirements
- R1: View 0 (`csr_view`=0) reads {24'b0, rounding mode in bits 7:5, flags in bits 4:0}, with flag bits NX=0, UF=1, OF=2, DZ=3, NV=4. A write through view 0 loads both fields from those bit positions. Bits 31:8 always read as zero and writes to them have no effect.
- R2: View 1 reads the rounding mode in bits 2:0 with all other bits zero. A write through view 1 loads the rounding mode from bits 2:0 and leaves the flags unchanged. The rounding mode changes only by a software write.
- R3: View 2 reads the flags in bits 4:0 with all other bits zero. A write through view 2 loads the flags from bits 4:0 and leaves the rounding mode unchanged.
- R4: Every bit set on `flag_acc` in a cycle is set in the flags after that clock edge. Hardware never clears a flag bit.
- R5: When a software write of the flags (view 0 or 2) and `flag_acc` occur in the same cycle, the new flags equal the written value ORed with `flag_acc`.
- R6: View 3 reads the context status in bits 1:0. A software write of value v through bits 1:0 takes effect only if bit v of `FS_LEGAL` is set. Otherwise the context status keeps its previous value. The context status always holds a legal value.
- R7: With `FS_POLICY` = precise, a cycle with `fpr_write` high sets the context status to 3 after that edge. This takes priority over a software write in the same cycle.
- R8: With `FS_POLICY` = never, `fpr_write` has no effect on the context status.
- R9: Out of reset, bits 31:8 of every view read zero and the context status holds a legal value. Software must not rely on any particular reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Software write enable for the selected view |
| csr_view | input | 2 | View select: 0 control word, 1 rounding mode, 2 flags, 3 context status |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Read data of the selected view (combinational) |
| flag_acc | input | 5 | Exception bits raised this cycle, ORed into the flags |
| fpr_write | input | 1 | A floating-point register is written this cycle |
| rmode_o | output | 3 | Current rounding mode, for the arithmetic units |
| fs_o | output | 2 | Current context status |

## Verification
A corrupted flag register appears at the ports on the next read of view 0 or view 2. A flag bit that was lost reads as zero one cycle after `flag_acc` set it, and it does not come back. A wrong context-status update appears on `fs_o` right after the clock edge that carries `fpr_write` or the software write. This includes a missed Dirty transition, a value outside the legal mask, or a software value that wins over the hardware strobe. A decode error between views shows up as a field that changes when a write targets the other field. The checks therefore read the untouched field back after each view write.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;

  localparam int unsigned CSR_W   = 32;
  localparam int unsigned FLAG_W  = 5;
  localparam int unsigned RM_W    = 3;
  localparam int unsigned FS_W    = 2;
  localparam int unsigned RM_LSB  = FLAG_W;
  localparam int unsigned USED_W  = RM_W + FLAG_W;
  localparam int unsigned FS_NVAL = 1 << FS_W;

  localparam logic [FS_W-1:0] FS_OFF   = '0;
  localparam logic [FS_W-1:0] FS_DIRTY = '1;

  typedef enum logic {
    FS_UPD_NEVER   = 1'b0,
    FS_UPD_PRECISE = 1'b1
  } fs_policy_e;

  typedef enum logic [1:0] {
    VIEW_ALL   = 2'd0,
    VIEW_RMODE = 2'd1,
    VIEW_FLAGS = 2'd2,
    VIEW_CTX   = 2'd3
  } csr_view_e;

  // Control word: rounding mode above the flags, upper bits zero.
  function automatic logic [CSR_W-1:0] pack_ctrl(input logic [RM_W-1:0] rm,
                                                 input logic [FLAG_W-1:0] fl);
    logic [CSR_W-1:0] w;
    w = '0;
    w[RM_LSB +: RM_W] = rm;
    w[0 +: FLAG_W]    = fl;
    return w;
  endfunction

  function automatic logic [CSR_W-1:0] view_read(input logic [1:0] view,
                                                 input logic [RM_W-1:0] rm,
                                                 input logic [FLAG_W-1:0] fl,
                                                 input logic [FS_W-1:0] fs);
    logic [CSR_W-1:0] w;
    w = '0;
    case (view)
      VIEW_ALL:   w = pack_ctrl(rm, fl);
      VIEW_RMODE: w[0 +: RM_W] = rm;
      VIEW_FLAGS: w[0 +: FLAG_W] = fl;
      default:    w[0 +: FS_W] = fs;
    endcase
    return w;
  endfunction

  function automatic logic fs_is_legal(input logic [FS_NVAL-1:0] mask,
                                       input logic [FS_W-1:0] val);
    return mask[val];
  endfunction

  // Sticky merge: software value (if any) first, then raised bits ORed in.
  function automatic logic [FLAG_W-1:0] flags_next(input logic [FLAG_W-1:0] cur,
                                                   input logic sw_wr,
                                                   input logic [FLAG_W-1:0] sw_val,
                                                   input logic [FLAG_W-1:0] acc);
    return (sw_wr ? sw_val : cur) | acc;
  endfunction

endpackage

// File: rtl/fpctl_csrdec.sv
module fpctl_csrdec
  import fpctl_pkg::*;
(
  input  logic              csr_we,
  input  logic [1:0]        csr_view,
  input  logic [CSR_W-1:0]  csr_wdata,
  input  logic [RM_W-1:0]   rm_q,
  input  logic [FLAG_W-1:0] flags_q,
  input  logic [FS_W-1:0]   fs_q,
  output logic              rm_sw_wr,
  output logic [RM_W-1:0]   rm_sw_val,
  output logic              flag_sw_wr,
  output logic [FLAG_W-1:0] flag_sw_val,
  output logic              fs_sw_wr,
  output logic [FS_W-1:0]   fs_sw_val,
  output logic [CSR_W-1:0]  csr_rdata
);

  always_comb begin
    rm_sw_wr    = 1'b0;
    rm_sw_val   = csr_wdata[0 +: RM_W];
    flag_sw_wr  = 1'b0;
    flag_sw_val = csr_wdata[0 +: FLAG_W];
    fs_sw_wr    = 1'b0;
    fs_sw_val   = csr_wdata[0 +: FS_W];
    if (csr_we) begin
      case (csr_view)
        VIEW_ALL: begin
          rm_sw_wr   = 1'b1;
          rm_sw_val  = csr_wdata[RM_LSB +: RM_W];
          flag_sw_wr = 1'b1;
        end
        VIEW_RMODE: rm_sw_wr   = 1'b1;
        VIEW_FLAGS: flag_sw_wr = 1'b1;
        default:    fs_sw_wr   = 1'b1;
      endcase
    end
  end

  assign csr_rdata = view_read(csr_view, rm_q, flags_q, fs_q);

endmodule

// File: rtl/fpctl_flags.sv
module fpctl_flags
  import fpctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [FLAG_W-1:0] sw_val,
  input  logic [FLAG_W-1:0] acc,
  output logic [FLAG_W-1:0] flags_q
);

  logic [FLAG_W-1:0] flags_d;

  assign flags_d = flags_next(flags_q, sw_wr, sw_val, acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

endmodule

// File: rtl/fpctl_rmode.sv
module fpctl_rmode
  import fpctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_wr,
  input  logic [RM_W-1:0] sw_val,
  output logic [RM_W-1:0] rm_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rm_q <= '0;
    else if (sw_wr) rm_q <= sw_val;
  end

endmodule

// File: rtl/fpctl_ctxstat.sv
module fpctl_ctxstat
  import fpctl_pkg::*;
#(
  parameter fs_policy_e       POLICY = FS_UPD_PRECISE,
  parameter logic [FS_NVAL-1:0] LEGAL = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_wr,
  input  logic [FS_W-1:0] sw_val,
  input  logic            fpr_write,
  output logic            hw_dirty,
  output logic            sw_accept,
  output logic [FS_W-1:0] fs_q
);

  if (POLICY == FS_UPD_PRECISE) begin : g_precise
    assign hw_dirty = fpr_write;
  end else begin : g_never
    logic unused_fpr;
    assign unused_fpr = fpr_write;
    assign hw_dirty   = 1'b0;
  end

  assign sw_accept = sw_wr && fs_is_legal(LEGAL, sw_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fs_q <= FS_OFF;
    else if (hw_dirty)  fs_q <= FS_DIRTY;
    else if (sw_accept) fs_q <= sw_val;
  end

endmodule

// File: rtl/fpctl_tracker.sv
module fpctl_tracker
  import fpctl_pkg::*;
#(
  parameter fs_policy_e       FS_POLICY = FS_UPD_PRECISE,
  parameter logic [FS_NVAL-1:0] FS_LEGAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_view,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  input  logic [FLAG_W-1:0] flag_acc,
  input  logic              fpr_write,
  output logic [RM_W-1:0]   rmode_o,
  output logic [FS_W-1:0]   fs_o
);

  // Configuration check: Off and Dirty must both be software-legal.
  if (!FS_LEGAL[FS_OFF] || !FS_LEGAL[FS_DIRTY]) begin : g_cfg_bad
    initial $error("fpctl_tracker: FS_LEGAL must allow Off and Dirty");
  end

  logic [RM_W-1:0]   rm_q;
  logic [FLAG_W-1:0] flags_q;
  logic [FS_W-1:0]   fs_q;
  logic              rm_sw_wr, flag_sw_wr, fs_sw_wr;
  logic [RM_W-1:0]   rm_sw_val;
  logic [FLAG_W-1:0] flag_sw_val;
  logic [FS_W-1:0]   fs_sw_val;
  logic              fs_hw_dirty, fs_sw_accept;

  fpctl_csrdec u_dec (
    .csr_we     (csr_we),
    .csr_view   (csr_view),
    .csr_wdata  (csr_wdata),
    .rm_q       (rm_q),
    .flags_q    (flags_q),
    .fs_q       (fs_q),
    .rm_sw_wr   (rm_sw_wr),
    .rm_sw_val  (rm_sw_val),
    .flag_sw_wr (flag_sw_wr),
    .flag_sw_val(flag_sw_val),
    .fs_sw_wr   (fs_sw_wr),
    .fs_sw_val  (fs_sw_val),
    .csr_rdata  (csr_rdata)
  );

  fpctl_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_wr  (flag_sw_wr),
    .sw_val (flag_sw_val),
    .acc    (flag_acc),
    .flags_q(flags_q)
  );

  fpctl_rmode u_rmode (
    .clk   (clk),
    .rst_n (rst_n),
    .sw_wr (rm_sw_wr),
    .sw_val(rm_sw_val),
    .rm_q  (rm_q)
  );

  fpctl_ctxstat #(.POLICY(FS_POLICY), .LEGAL(FS_LEGAL)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_wr    (fs_sw_wr),
    .sw_val   (fs_sw_val),
    .fpr_write(fpr_write),
    .hw_dirty (fs_hw_dirty),
    .sw_accept(fs_sw_accept),
    .fs_q     (fs_q)
  );

  assign rmode_o = rm_q;
  assign fs_o    = fs_q;

endmodule

// File: rtl/fpctl_tracker_chk.sv
module fpctl_tracker_chk
  import fpctl_pkg::*;
#(
  parameter fs_policy_e       FS_POLICY = FS_UPD_PRECISE,
  parameter logic [FS_NVAL-1:0] FS_LEGAL = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CSR_W-1:0]  csr_wdata,
  input logic [CSR_W-1:0]  csr_rdata,
  input logic [FLAG_W-1:0] flag_acc,
  input logic              fpr_write,
  input logic [RM_W-1:0]   rm_q,
  input logic [FLAG_W-1:0] flags_q,
  input logic [FS_W-1:0]   fs_q,
  input logic              rm_sw_wr,
  input logic              flag_sw_wr,
  input logic              fs_sw_wr,
  input logic [FS_W-1:0]   fs_sw_val
);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[CSR_W-1:USED_W] == '0); // R1

  AST_RM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rm_sw_wr |=> $stable(rm_q)); // R2

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_sw_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4

  AST_FLAGS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_acc != '0) |=> ((flags_q & $past(flag_acc)) == $past(flag_acc))); // R4

  AST_FLAGS_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sw_wr |=> (flags_q == ($past(csr_wdata[FLAG_W-1:0]) | $past(flag_acc)))); // R5

  AST_FS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    FS_LEGAL[fs_q]); // R6

  AST_FS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_sw_wr && !FS_LEGAL[fs_sw_val] && !fpr_write) |=> $stable(fs_q)); // R6

  if (FS_POLICY == FS_UPD_PRECISE) begin : g_precise
    AST_FS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      fpr_write |=> (fs_q == FS_DIRTY)); // R7
  end else begin : g_never
    AST_FS_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_sw_wr |=> $stable(fs_q)); // R8
  end

endmodule

bind fpctl_tracker fpctl_tracker_chk #(.FS_POLICY(FS_POLICY), .FS_LEGAL(FS_LEGAL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_wdata (csr_wdata),
  .csr_rdata (csr_rdata),
  .flag_acc  (flag_acc),
  .fpr_write (fpr_write),
  .rm_q      (rm_q),
  .flags_q   (flags_q),
  .fs_q      (fs_q),
  .rm_sw_wr  (rm_sw_wr),
  .flag_sw_wr(flag_sw_wr),
  .fs_sw_wr  (fs_sw_wr),
  .fs_sw_val (fs_sw_val)
);

// File: tb/test_fpctl_tracker.sv
module test_fpctl_tracker;
  import fpctl_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_view = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [4:0]  flag_acc = '0;
  logic        fpr_write = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic [2:0]  rm_a, rm_b;
  logic [1:0]  fs_a, fs_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  // Precise policy, every value legal.
  fpctl_tracker #(.FS_POLICY(FS_UPD_PRECISE), .FS_LEGAL(4'b1111)) i_fpctl_tracker (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_view(csr_view),
    .csr_wdata(csr_wdata), .csr_rdata(rd_a), .flag_acc(flag_acc),
    .fpr_write(fpr_write), .rmode_o(rm_a), .fs_o(fs_a));

  // Never policy, only Off (0) and Dirty (3) legal.
  fpctl_tracker #(.FS_POLICY(FS_UPD_NEVER), .FS_LEGAL(4'b1001)) i_fpctl_tracker_nv (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_view(csr_view),
    .csr_wdata(csr_wdata), .csr_rdata(rd_b), .flag_acc(flag_acc),
    .fpr_write(fpr_write), .rmode_o(rm_b), .fs_o(fs_b));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus from a negedge, return at the next negedge.
  task automatic cyc(input logic we, input logic [1:0] v, input logic [31:0] d,
                     input logic [4:0] acc, input logic fw);
    csr_we = we; csr_view = v; csr_wdata = d; flag_acc = acc; fpr_write = fw;
    @(posedge clk);
    @(negedge clk);
    csr_we = 1'b0; flag_acc = '0; fpr_write = 1'b0; csr_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] v, output logic [31:0] a, output logic [31:0] b);
    csr_view = v;
    #1;
    a = rd_a;
    b = rd_b;
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    for (int v = 0; v < 4; v++) begin
      rd(v[1:0], a, b);
      chk("R9", "upper bits after reset", {a[31:8], b[31:8]}, '0);
    end
    rd(2'd3, a, b);
    chk("R9", "never-instance fs legal after reset", 32'(b == 0 || b == 3), 32'd1);
    // Establish known state by software.
    cyc(1'b1, 2'd0, 32'h0, 5'h0, 1'b0);
    cyc(1'b1, 2'd3, 32'h0, 5'h0, 1'b0);
  endtask

  task automatic t_full_view();
    logic [31:0] a, b;
    cyc(1'b1, 2'd0, 32'hFFFF_FFA5, 5'h0, 1'b0);
    rd(2'd0, a, b);
    chk("R1", "view0 after write A5", a, 32'h0000_00A5);
    chk("R1", "view0 second instance", b, 32'h0000_00A5);
    chk("R1", "rmode_o from bits 7:5", 32'(rm_a), 32'd5);
    rd(2'd1, a, b);
    chk("R2", "view1 rounding mode", a, 32'd5);
    rd(2'd2, a, b);
    chk("R3", "view2 flags", a, 32'h05);
  endtask

  task automatic t_rm_view();
    logic [31:0] a, b;
    cyc(1'b1, 2'd1, 32'hFFFF_FFF2, 5'h0, 1'b0);
    rd(2'd0, a, b);
    chk("R2", "view1 write keeps flags", a, 32'h0000_0045);
    rd(2'd1, a, b);
    chk("R2", "view1 read upper zero", a, 32'd2);
  endtask

  task automatic t_flag_view();
    logic [31:0] a, b;
    cyc(1'b1, 2'd2, 32'hFFFF_FFFA, 5'h0, 1'b0);
    rd(2'd0, a, b);
    chk("R3", "view2 write keeps rmode", a, 32'h0000_005A);
    rd(2'd2, a, b);
    chk("R3", "view2 read", a, 32'h1A);
  endtask

  task automatic t_accumulate();
    logic [31:0] a, b;
    cyc(1'b1, 2'd2, 32'h0, 5'h0, 1'b0);
    cyc(1'b0, 2'd0, 32'h0, 5'b00001, 1'b0);
    rd(2'd2, a, b);
    chk("R4", "NX accumulated", a, 32'h01);
    cyc(1'b0, 2'd0, 32'h0, 5'b10000, 1'b0);
    rd(2'd2, a, b);
    chk("R4", "NV accumulated, NX sticky", a, 32'h11);
    cyc(1'b0, 2'd0, 32'h0, 5'h0, 1'b0);
    cyc(1'b0, 2'd0, 32'h0, 5'b00001, 1'b0);
    rd(2'd2, a, b);
    chk("R4", "idle and repeat keep flags", a, 32'h11);
  endtask

  task automatic t_merge();
    logic [31:0] a, b;
    cyc(1'b1, 2'd2, 32'h02, 5'b01000, 1'b0);
    rd(2'd2, a, b);
    chk("R5", "view2 write ORed with acc", a, 32'h0A);
    cyc(1'b1, 2'd0, 32'h0, 5'b00100, 1'b0);
    rd(2'd0, a, b);
    chk("R5", "view0 clear ORed with acc", a, 32'h04);
  endtask

  task automatic t_fs_sw();
    logic [31:0] a, b;
    cyc(1'b1, 2'd3, 32'hFFFF_FFFD, 5'h0, 1'b0);
    rd(2'd3, a, b);
    chk("R6", "legal fs=1 accepted", a, 32'd1);
    chk("R6", "illegal fs=1 dropped", b, 32'd0);
    cyc(1'b1, 2'd3, 32'h3, 5'h0, 1'b0);
    rd(2'd3, a, b);
    chk("R6", "fs=3 accepted", a, 32'd3);
    chk("R6", "fs=3 accepted second", b, 32'd3);
    cyc(1'b1, 2'd3, 32'h2, 5'h0, 1'b0);
    rd(2'd3, a, b);
    chk("R6", "fs=2 accepted", a, 32'd2);
    chk("R6", "fs=2 dropped keeps 3", b, 32'd3);
    cyc(1'b1, 2'd3, 32'h0, 5'h0, 1'b0);
    chk("R6", "fs_o after write 0", {fs_a, fs_b}, 32'd0);
  endtask

  task automatic t_fs_hw();
    logic [31:0] a, b;
    cyc(1'b0, 2'd0, 32'h0, 5'h0, 1'b1);
    chk("R7", "fpr_write sets Dirty", 32'(fs_a), 32'd3);
    chk("R8", "never policy ignores fpr_write", 32'(fs_b), 32'd0);
    cyc(1'b1, 2'd3, 32'h2, 5'h0, 1'b0);
    cyc(1'b0, 2'd0, 32'h0, 5'h0, 1'b0);
    chk("R7", "no strobe keeps fs", 32'(fs_a), 32'd2);
    cyc(1'b1, 2'd3, 32'h1, 5'h0, 1'b1);
    chk("R7", "strobe beats sw write", 32'(fs_a), 32'd3);
    chk("R8", "never: illegal sw with strobe", 32'(fs_b), 32'd0);
    rd(2'd0, a, b);
    chk("R1", "fs write leaves control word", a, 32'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_view();
    t_rm_view();
    t_flag_view();
    t_accumulate();
    t_merge();
    t_fs_sw();
    t_fs_hw();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule